// File: doc/BRIEF.md
# Adder-Tree Population Counter (31 bits)

This block counts how many bits are set in a 31-bit data word and reports the count as a 5-bit number from 0 to 31. The reduction uses a fixed tree of small adders. Eight 3-input full adders first compress 24 of the raw bits into 2-bit partial counts. Three further levels of ripple adders then merge pairs of partial counts. Each of those adders takes one of the remaining 7 raw bits as its carry-in. Because of this, exactly 31 bits fold into a 5-bit result with no padding and no extra terms.

A valid flag travels alongside the data. The parameter `PIPE_STAGES` selects from 0 to 3 register stages. The stages are placed after the last merge level first, then after the third level, then after the second level, so the designer can trade latency for logic depth. When `PIPE_STAGES` is 0 the block is purely combinational.

Top module: `popc31`

## Requirements
- R1: Whenever `out_valid` is high, `out_count` equals the number of ones in the `in_data` word that entered with the matching `in_valid`, over the range 0 to 31.
- R2: Every input bit is counted exactly once. A word with only bit i set yields a count of 1 for every i from 0 to 30.
- R3: Leaf full adder k (k = 0..7) takes bits 3k+2..3k. Bits 24..27 are the carry-ins of the four second-level adders, bits 28..29 those of the two third-level adders, and bit 30 that of the final adder. A word with only bits 24..30 set counts 7.
- R4: An all-zero word counts 0 and an all-ones word counts 31.
- R5: The latency from `in_valid`/`in_data` to `out_valid`/`out_count` is exactly `PIPE_STAGES` cycles (0 to 3), and `out_valid` is `in_valid` delayed by that amount.
- R6: With `PIPE_STAGES` ≥ 1, the stage data registers load only with a valid entry, so `out_count` holds its last result while no new valid word arrives.
- R7: A synchronous active-high `rst` clears every stage register: one clock edge with `rst` high gives `out_valid` = 0 and `out_count` = 0 (for `PIPE_STAGES` ≥ 1).
- R8: Valid words presented on consecutive cycles emerge on consecutive cycles, in order, each with its own count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the stage registers |
| in_valid | input | 1 | Marks `in_data` as a word to count |
| in_data | input | 31 | Word whose set bits are counted |
| out_valid | output | 1 | Marks `out_count` as a result |
| out_count | output | 5 | Number of set bits, 0 to 31 |

## Verification
The all-zero and all-ones words probe the two ends of the range and the full carry propagation through every level. Walking a single one across all 31 positions shows that no bit is dropped or counted twice, and it separates the leaf inputs from each carry-in position. A word with only the seven carry-in bits set, alternating patterns, and random words show that the partial counts are combined with the right weights. A back-to-back stream, a valid pulse followed by idle cycles, and a mid-run reset tell apart latency, ordering, holding, and clearing across all four pipeline settings, which run side by side.

// File: rtl/popc_pkg.sv
package popc_pkg;
    localparam int IN_W      = 31;
    localparam int OUT_W     = $clog2(IN_W + 1);
    localparam int L1_W      = 2;
    localparam int L2_W      = L1_W + 1;
    localparam int L3_W      = L2_W + 1;
    localparam int N_FA      = 8;
    localparam int N_L2      = N_FA / 2;
    localparam int N_L3      = N_L2 / 2;
    localparam int LEAF_BITS = N_FA * 3;
    localparam int L2_CIN0   = LEAF_BITS;
    localparam int L3_CIN0   = L2_CIN0 + N_L2;
    localparam int L4_CIN    = L3_CIN0 + N_L3;
    localparam int RAW_A_W   = IN_W - L3_CIN0;
    localparam int STA_W     = N_L2 * L2_W + RAW_A_W;
    localparam int STB_W     = N_L3 * L3_W + 1;
endpackage

// File: rtl/popc_fa.sv
module popc_fa (
    input  logic [2:0] bits,
    output logic [1:0] cnt
);
    always_comb begin
        cnt[0] = bits[0] ^ bits[1] ^ bits[2];
        cnt[1] = (bits[0] & bits[1]) | (bits[0] & bits[2]) | (bits[1] & bits[2]);
    end
endmodule

// File: rtl/popc_merge.sv
module popc_merge #(
    parameter int W = 2
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W:0]   sum
);
    logic [W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]     = a[i] ^ b[i] ^ carry[i];
        assign carry[i+1] = (a[i] & b[i]) | (a[i] & carry[i]) | (b[i] & carry[i]);
    end

    assign sum[W] = carry[W];
endmodule

// File: rtl/popc_stage.sv
module popc_stage #(
    parameter int W  = 8,
    parameter bit EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [W-1:0] in_dat,
    output logic         out_vld,
    output logic [W-1:0] out_dat
);
    typedef struct packed {
        logic         vld;
        logic [W-1:0] dat;
    } stage_t;

    stage_t state_d, state_q;

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_vld;
        if (in_vld) begin
            state_d.dat = in_dat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_vld = EN ? state_q.vld : in_vld;
    assign out_dat = EN ? state_q.dat : in_dat;

    if (EN) begin : g_chk
        assert_valid_delay_R5: assert property (@(posedge clk) disable iff (rst)
            in_vld |=> out_vld);
        assert_idle_delay_R5: assert property (@(posedge clk) disable iff (rst)
            !in_vld |=> !out_vld);
        assert_data_load_R8: assert property (@(posedge clk) disable iff (rst)
            in_vld |=> out_dat == $past(in_dat));
        assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
            !in_vld |=> $stable(out_dat));
        assert_reset_clear_R7: assert property (@(posedge clk)
            rst |=> (!out_vld && out_dat == '0));
    end
endmodule

// File: rtl/popc31.sv
module popc31
    import popc_pkg::*;
#(
    parameter int PIPE_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [IN_W-1:0]  in_data,
    output logic             out_valid,
    output logic [OUT_W-1:0] out_count
);
    localparam bit EN_A = (PIPE_STAGES >= 3);
    localparam bit EN_B = (PIPE_STAGES >= 2);
    localparam bit EN_C = (PIPE_STAGES >= 1);

    // level 1: leaf full adders on bits [LEAF_BITS-1:0]
    logic [L1_W-1:0] l1_cnt [N_FA];
    for (genvar k = 0; k < N_FA; k++) begin : g_leaf
        popc_fa u_fa (
            .bits (in_data[3*k +: 3]),
            .cnt  (l1_cnt[k])
        );
    end

    // level 2: pairs of leaf counts, carry-in from bits L2_CIN0..
    logic [L2_W-1:0] l2_sum [N_L2];
    for (genvar j = 0; j < N_L2; j++) begin : g_l2
        popc_merge #(.W(L1_W)) u_add (
            .a   (l1_cnt[2*j]),
            .b   (l1_cnt[2*j+1]),
            .cin (in_data[L2_CIN0 + j]),
            .sum (l2_sum[j])
        );
    end

    // stage A: level-2 sums plus the raw bits still waiting
    logic [STA_W-1:0] sta_in, sta_out;
    logic             sta_vld;
    for (genvar j = 0; j < N_L2; j++) begin : g_pack_a
        assign sta_in[j*L2_W +: L2_W] = l2_sum[j];
    end
    assign sta_in[N_L2*L2_W +: RAW_A_W] = in_data[L3_CIN0 +: RAW_A_W];

    popc_stage #(.W(STA_W), .EN(EN_A)) u_sta (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_valid),
        .in_dat  (sta_in),
        .out_vld (sta_vld),
        .out_dat (sta_out)
    );

    // level 3: carry-in from bits L3_CIN0..
    logic [L3_W-1:0] l3_sum [N_L3];
    for (genvar j = 0; j < N_L3; j++) begin : g_l3
        popc_merge #(.W(L2_W)) u_add (
            .a   (sta_out[(2*j)*L2_W +: L2_W]),
            .b   (sta_out[(2*j+1)*L2_W +: L2_W]),
            .cin (sta_out[N_L2*L2_W + j]),
            .sum (l3_sum[j])
        );
    end

    // stage B: level-3 sums plus the final carry-in bit
    logic [STB_W-1:0] stb_in, stb_out;
    logic             stb_vld;
    for (genvar j = 0; j < N_L3; j++) begin : g_pack_b
        assign stb_in[j*L3_W +: L3_W] = l3_sum[j];
    end
    assign stb_in[STB_W-1] = sta_out[N_L2*L2_W + (L4_CIN - L3_CIN0)];

    popc_stage #(.W(STB_W), .EN(EN_B)) u_stb (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (sta_vld),
        .in_dat  (stb_in),
        .out_vld (stb_vld),
        .out_dat (stb_out)
    );

    // level 4: final adder, carry-in is the last raw bit
    logic [OUT_W-1:0] l4_sum;
    popc_merge #(.W(L3_W)) u_final (
        .a   (stb_out[0 +: L3_W]),
        .b   (stb_out[L3_W +: L3_W]),
        .cin (stb_out[STB_W-1]),
        .sum (l4_sum)
    );

    popc_stage #(.W(OUT_W), .EN(EN_C)) u_stc (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (stb_vld),
        .in_dat  (l4_sum),
        .out_vld (out_valid),
        .out_dat (out_count)
    );

    // end-to-end count check against a reference popcount, per latency
    if (PIPE_STAGES == 0) begin : g_chk0
        assert_count_R1: assert property (@(posedge clk) disable iff (rst)
            in_valid |-> out_count == OUT_W'($countones(in_data)));
        assert_zero_latency_R5: assert property (@(posedge clk) disable iff (rst)
            out_valid == in_valid);
    end else if (PIPE_STAGES == 1) begin : g_chk1
        assert_count_R1: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> out_count == OUT_W'($countones($past(in_data, 1))));
    end else if (PIPE_STAGES == 2) begin : g_chk2
        assert_count_R1: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> out_count == OUT_W'($countones($past(in_data, 2))));
    end else begin : g_chk3
        assert_count_R1: assert property (@(posedge clk) disable iff (rst)
            out_valid |-> out_count == OUT_W'($countones($past(in_data, 3))));
    end
endmodule

// File: tb/sim_popc31.sv
module sim_popc31;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 11;
    localparam int NSTREAM    = 8;

    // entry layout: {expected count[35:31], data word[30:0]}
    localparam logic [35:0] VEC [NVEC] = '{
        {5'd0,  31'h0000_0000},
        {5'd31, 31'h7FFF_FFFF},
        {5'd3,  31'h0000_0007},
        {5'd4,  31'h0F00_0000},
        {5'd7,  31'h7F00_0000},
        {5'd24, 31'h00FF_FFFF},
        {5'd16, 31'h5555_5555},
        {5'd15, 31'h2AAA_AAAA},
        {5'd2,  31'h4000_0001},
        {5'd8,  31'h1248_1248},
        {5'd3,  31'h7000_0000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [30:0] in_data = '0;
    logic        v0, v1, v2, v3;
    logic [4:0]  c0, c1, c2, c3;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    popc31 #(.PIPE_STAGES(0)) u0 (.clk(clk), .rst(rst), .in_valid(in_valid),
        .in_data(in_data), .out_valid(v0), .out_count(c0));
    popc31 #(.PIPE_STAGES(1)) u1 (.clk(clk), .rst(rst), .in_valid(in_valid),
        .in_data(in_data), .out_valid(v1), .out_count(c1));
    popc31 #(.PIPE_STAGES(2)) u2 (.clk(clk), .rst(rst), .in_valid(in_valid),
        .in_data(in_data), .out_valid(v2), .out_count(c2));
    popc31 #(.PIPE_STAGES(3)) u3 (.clk(clk), .rst(rst), .in_valid(in_valid),
        .in_data(in_data), .out_valid(v3), .out_count(c3));

    function automatic logic [4:0] ref_count(input logic [30:0] w);
        logic [4:0] n = '0;
        for (int i = 0; i < 31; i++) n = n + 5'(w[i]);
        return n;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // one valid word, then idle; each pipe depth checked at its own cycle
    task automatic apply_one(input logic [30:0] w, input logic [4:0] exp, input string req);
        @(negedge clk);
        in_data  = w;
        in_valid = 1'b1;
        #1;
        chk({req, " depth0 count"}, c0, exp);
        chk({req, " depth0 valid R5"}, v0, 1);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = ~w;
        chk({req, " depth1 count"}, c1, exp);
        chk({req, " depth1 valid R5"}, v1, 1);
        @(negedge clk);
        chk({req, " depth2 count"}, c2, exp);
        chk({req, " depth2 valid R5"}, v2, 1);
        chk("R6 depth1 hold count", c1, exp);
        chk("R5 depth1 valid drop", v1, 0);
        @(negedge clk);
        chk({req, " depth3 count"}, c3, exp);
        chk({req, " depth3 valid R5"}, v3, 1);
        chk("R6 depth2 hold count", c2, exp);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [30:0] w;
        logic [4:0]  sexp [NSTREAM];
        logic [30:0] sdat [NSTREAM];

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R7: state right after reset
        chk("R7 depth1 valid", v1, 0);
        chk("R7 depth1 count", c1, 0);
        chk("R7 depth2 valid", v2, 0);
        chk("R7 depth3 valid", v3, 0);
        chk("R7 depth3 count", c3, 0);

        // table walk (R1, R3, R4)
        for (int i = 0; i < NVEC; i++) begin
            apply_one(VEC[i][30:0], VEC[i][35:31], "R1 table");
        end
        apply_one(31'h0000_0000, 5'd0, "R4 zeros");
        apply_one(31'h7FFF_FFFF, 5'd31, "R4 ones");
        apply_one(31'h7F00_0000, 5'd7, "R3 carry-in bits");

        // R2: walking single one
        for (int b = 0; b < 31; b++) begin
            apply_one(31'(1) << b, 5'd1, "R2 walking bit");
        end

        // random words against behavioural count (R1)
        for (int r = 0; r < 150; r++) begin
            w = 31'($urandom);
            apply_one(w, ref_count(w), "R1 random");
        end

        // R8: back-to-back stream
        for (int i = 0; i < NSTREAM; i++) begin
            sdat[i] = 31'($urandom) ^ (31'h1 << i);
            sexp[i] = ref_count(sdat[i]);
        end
        for (int i = 0; i < NSTREAM + 4; i++) begin
            @(negedge clk);
            if (i >= 1 && i - 1 < NSTREAM) begin
                chk("R8 depth1 stream count", c1, sexp[i-1]);
                chk("R8 depth1 stream valid", v1, 1);
            end
            if (i >= 3 && i - 3 < NSTREAM) begin
                chk("R8 depth3 stream count", c3, sexp[i-3]);
                chk("R8 depth3 stream valid", v3, 1);
            end
            if (i < NSTREAM) begin
                in_data  = sdat[i];
                in_valid = 1'b1;
                #1;
                chk("R8 depth0 stream count", c0, sexp[i]);
            end else begin
                in_valid = 1'b0;
                in_data  = '0;
            end
        end
        @(negedge clk);
        chk("R5 depth3 valid after stream", v3, 0);

        // R7: reset in the middle of a flight
        @(negedge clk);
        in_data  = 31'h7FFF_FFFF;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        chk("R7 pre-reset depth1 valid", v1, 1);
        @(negedge clk);
        chk("R7 depth1 valid cleared", v1, 0);
        chk("R7 depth1 count cleared", c1, 0);
        chk("R7 depth2 valid cleared", v2, 0);
        chk("R7 depth2 count cleared", c2, 0);
        chk("R7 depth3 valid cleared", v3, 0);
        chk("R7 depth3 count cleared", c3, 0);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk("R7 depth3 stays idle", v3, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule